// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block runs one AUX request/reply exchange on top of a separate register engine. When `start` is pulsed it first checks the requested lengths. A request that is too long is refused at once. Otherwise it samples the channel busy flag up to three times, with a wait of about one millisecond between samples. If the channel never goes idle, the block gives up without launching anything.

Once the channel is idle, the block walks a small table of bit-clock divider values. Each table entry gets a bounded number of attempts. Before each attempt the engine's status is cleared and its data registers are reloaded, and then the engine is launched with the current divider. The engine's reply decides what happens next:

- A timeout is retried straight away.
- A receive error is retried only after a back-off of about 400 µs.
- A clean completion ends the exchange.
- When the attempts at one divider run out, the next divider is tried.
- A zero entry ends the table. The result then reflects the last error seen.

The divider table has two variants:

- A single entry close to a 2 MHz bit clock. It is computed as the clock in kHz divided by 2000, rounded to nearest.
- A fixed pair of entries, 63 and then 72.

The state walk runs in this order:

- IDLE leaves on start, either to DONE (request too big) or to CHECK.
- CHECK goes to SEL when the channel is idle. When the channel is busy it goes to POLL, or to DONE after the third busy sample.
- POLL returns to CHECK when the wait timer expires.
- SEL goes to DONE on a zero divider and to PREP otherwise.
- PREP always goes to KICK, and KICK always goes to WAIT.
- WAIT handles the engine's finish:
  - A timeout advances at once.
  - A receive error goes to BACK.
  - A completion goes to DONE.
  - A finish with no flag set advances.
- BACK advances when its timer expires.
- "Advance" means PREP while attempts remain, and NEXT once they are used up.
- NEXT goes to SEL.
- DONE goes to IDLE.

Top module: `aux_retry_seq`

## Requirements
- R1: If `send_len` or `recv_cap` exceeds 20 at start, `done` is asserted in the next cycle with result 4 (too big), and `eng_go` is never raised.
- R2: While `eng_busy` stays high, the busy flag is sampled three times, with at least POLL_CYC cycles between samples. The exchange then ends with result 1 (busy) and no `eng_go`.
- R3: Every attempt is one cycle with `eng_clr` and `eng_load` high, followed directly by one cycle with `eng_go` high.
- R4: After a finish that carries `eng_to_err`, with attempts left, `eng_go` rises two cycles after the finish cycle.
- R5: After a finish that carries `eng_rx_err`, at least BACKOFF_CYC cycles pass before the next `eng_go`.
- R6: Each divider entry gets at most MAX_TRY (5) attempts before the sequencer moves to the next entry.
- R7: The default table holds a single entry, round(CLK_KHZ/2000), which is 12 at 24000 kHz. The alternate table holds 63 and then 72. A zero entry ends the table, and `eng_div` is never zero during `eng_go`.
- R8: When the table runs out, the result is 2 (IO error) if the last failure was a receive error, and 3 (timeout) if it was a timeout.
- R9: A finish with `eng_ok` and no error gives result 0, with `rx_len` equal to the smaller of `eng_rx_len` and `recv_cap`.
- R10: A completed reply whose length is 0 or greater than 20 gives result 1 (busy).
- R11: `done` is a single-cycle pulse. `result` and `rx_len` hold their values until the next start.
- R12: After reset the block is idle, and `done`, `eng_go`, `eng_clr` and `eng_load` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one exchange (ignored unless idle) |
| send_len | input | LEN_W | Bytes to transmit |
| recv_cap | input | LEN_W | Caller's receive buffer size |
| eng_busy | input | 1 | Engine channel busy flag |
| eng_fin | input | 1 | Engine attempt finished (one-cycle pulse) |
| eng_ok | input | 1 | Attempt completed |
| eng_rx_err | input | 1 | Attempt ended with receive error |
| eng_to_err | input | 1 | Attempt ended with timeout |
| eng_rx_len | input | LEN_W | Byte count reported by engine |
| eng_clr | output | 1 | Write-1-to-clear engine status |
| eng_load | output | 1 | Reload engine data registers |
| eng_go | output | 1 | Launch an attempt |
| eng_div | output | DIV_W | Bit-clock divider for the attempt |
| done | output | 1 | Exchange finished pulse |
| result | output | 3 | 0 ok, 1 busy, 2 IO error, 3 timeout, 4 too big |
| rx_len | output | LEN_W | Received byte count after clipping |

## Verification
The retry loop is exercised with several engine reply streams:

- A run of timeouts shows the immediate relaunch, and against a run of receive errors it shows that only the error path waits for the back-off gap.
- Clean completions with short, long, zero and over-limit lengths separate the clipped success path from the forbidden-length busy path.
- Oversized requests and a channel that stays busy show that the two early exits launch nothing.
- The alternate-table instance, driven through ten timeouts, shows the move from 63 to 72 after five attempts and the end of the table at the zero entry.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

    localparam int MAX_BYTES = 20;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_BUSY    = 3'd1,
        RES_IO      = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_BIG     = 3'd4
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_POLL,
        ST_SEL,
        ST_PREP,
        ST_KICK,
        ST_WAIT,
        ST_BACK,
        ST_NEXT,
        ST_DONE
    } state_e;

endpackage

// File: rtl/aux_div_table.sv
module aux_div_table #(
    parameter int CLK_KHZ   = 24000,
    parameter int DIV_W     = 8,
    parameter int IDX_W     = 2,
    parameter bit ALT_TABLE = 1'b0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [DIV_W-1:0] div
);
    localparam int NEAR_DIV = (CLK_KHZ + 1000) / 2000;

    generate
        if (ALT_TABLE) begin : g_pair
            // two fixed entries, then the terminating zero
            always_comb begin
                if (idx == IDX_W'(0))      div = DIV_W'(63);
                else if (idx == IDX_W'(1)) div = DIV_W'(72);
                else                       div = '0;
            end
        end else begin : g_near
            // one entry close to a 2 MHz bit clock, then the terminating zero
            always_comb begin
                if (idx == IDX_W'(0)) div = DIV_W'(NEAR_DIV);
                else                  div = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/aux_retry_seq.sv
module aux_retry_seq
    import aux_retry_pkg::*;
#(
    parameter int CLK_KHZ     = 24000,
    parameter int POLL_CYC    = CLK_KHZ,
    parameter int BACKOFF_CYC = (CLK_KHZ * 2) / 5,
    parameter int MAX_TRY     = 5,
    parameter int POLLS       = 3,
    parameter int DIV_W       = 8,
    parameter int LEN_W       = 5,
    parameter bit ALT_TABLE   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] send_len,
    input  logic [LEN_W-1:0] recv_cap,
    input  logic             eng_busy,
    input  logic             eng_fin,
    input  logic             eng_ok,
    input  logic             eng_rx_err,
    input  logic             eng_to_err,
    input  logic [LEN_W-1:0] eng_rx_len,
    output logic             eng_clr,
    output logic             eng_load,
    output logic             eng_go,
    output logic [DIV_W-1:0] eng_div,
    output logic             done,
    output logic [2:0]       result,
    output logic [LEN_W-1:0] rx_len
);
    localparam int TW     = $clog2((POLL_CYC > BACKOFF_CYC ? POLL_CYC : BACKOFF_CYC) + 1);
    localparam int TRY_W  = $clog2(MAX_TRY + 1);
    localparam int PCNT_W = $clog2(POLLS + 1);
    localparam int IDX_W  = 2;

    state_e            st, st_nx;
    logic [PCNT_W-1:0] poll_cnt;
    logic [TRY_W-1:0]  try_cnt;
    logic [IDX_W-1:0]  div_idx;
    res_e              res_q, fail_q;
    logic [LEN_W-1:0]  len_q, cap_q;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              too_big, last_try;
    state_e            adv_st;

    aux_div_table #(.CLK_KHZ(CLK_KHZ), .DIV_W(DIV_W), .IDX_W(IDX_W), .ALT_TABLE(ALT_TABLE))
        u_tab (.idx(div_idx), .div(eng_div));

    aux_wait_timer #(.TW(TW))
        u_tmr (.clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp));

    assign too_big  = (send_len > LEN_W'(MAX_BYTES)) || (recv_cap > LEN_W'(MAX_BYTES));
    assign last_try = (try_cnt == TRY_W'(MAX_TRY));
    assign adv_st   = last_try ? ST_NEXT : ST_PREP;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = too_big ? ST_DONE : ST_CHECK;
            ST_CHECK: begin
                if (!eng_busy)                          st_nx = ST_SEL;
                else if (poll_cnt == PCNT_W'(POLLS - 1)) st_nx = ST_DONE;
                else                                    st_nx = ST_POLL;
            end
            ST_POLL:  if (tmr_exp) st_nx = ST_CHECK;
            ST_SEL:   st_nx = (eng_div == '0) ? ST_DONE : ST_PREP;
            ST_PREP:  st_nx = ST_KICK;
            ST_KICK:  st_nx = ST_WAIT;
            ST_WAIT: begin
                if (eng_fin) begin
                    if (eng_to_err)      st_nx = adv_st;
                    else if (eng_rx_err) st_nx = ST_BACK;
                    else if (eng_ok)     st_nx = ST_DONE;
                    else                 st_nx = adv_st;
                end
            end
            ST_BACK:  if (tmr_exp) st_nx = adv_st;
            ST_NEXT:  st_nx = ST_SEL;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        eng_clr  = (st == ST_PREP);
        eng_load = (st == ST_PREP);
        eng_go   = (st == ST_KICK);
        done     = (st == ST_DONE);
        tmr_load = (st == ST_CHECK && st_nx == ST_POLL) || (st == ST_WAIT && st_nx == ST_BACK);
        tmr_val  = (st == ST_CHECK) ? TW'(POLL_CYC) : TW'(BACKOFF_CYC);
    end

    assign result = res_q;
    assign rx_len = len_q;

    // counters and result bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
            try_cnt  <= '0;
            div_idx  <= '0;
            res_q    <= RES_OK;
            fail_q   <= RES_BUSY;
            len_q    <= '0;
            cap_q    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    cap_q    <= recv_cap;
                    len_q    <= '0;
                    poll_cnt <= '0;
                    fail_q   <= RES_BUSY;
                    res_q    <= too_big ? RES_BIG : RES_OK;
                end
                ST_CHECK: begin
                    if (!eng_busy) div_idx <= '0;
                    else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        if (st_nx == ST_DONE) res_q <= RES_BUSY;
                    end
                end
                ST_SEL: begin
                    try_cnt <= '0;
                    if (eng_div == '0) res_q <= fail_q;
                end
                ST_KICK: try_cnt <= try_cnt + 1'b1;
                ST_WAIT: if (eng_fin) begin
                    if (eng_to_err)      fail_q <= RES_TIMEOUT;
                    else if (eng_rx_err) fail_q <= RES_IO;
                    else if (eng_ok) begin
                        if (eng_rx_len == '0 || eng_rx_len > LEN_W'(MAX_BYTES))
                            res_q <= RES_BUSY;
                        else begin
                            res_q <= RES_OK;
                            len_q <= (eng_rx_len > cap_q) ? cap_q : eng_rx_len;
                        end
                    end else             fail_q <= RES_BUSY;
                end
                ST_NEXT: div_idx <= div_idx + 1'b1;
                default: ;
            endcase
        end
    end

    // back-off window watch: cycles since a receive-error finish
    logic [TW:0] gap_cnt;
    logic        rx_pend;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            rx_pend <= 1'b0;
        end else if (eng_fin && eng_rx_err && st == ST_WAIT) begin
            gap_cnt <= '0;
            rx_pend <= 1'b1;
        end else begin
            if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
            if (eng_go) rx_pend <= 1'b0;
        end
    end

    // R1
    big_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && too_big) |=> (done && result == 3'd4));
    // R3
    clr_before_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> $past(eng_clr && eng_load));
    // R4
    imm_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && eng_fin && eng_to_err && !last_try) |=> ##1 eng_go);
    // R5
    backoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && rx_pend) |-> (gap_cnt >= (TW+1)'(BACKOFF_CYC)));
    // R6
    try_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> (try_cnt < TRY_W'(MAX_TRY)));
    // R7
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> (eng_div != '0));
    // R9
    ok_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 3'd0) |-> (rx_len <= cap_q && rx_len <= LEN_W'(MAX_BYTES)));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && $stable(result) && $stable(rx_len)));

endmodule

// File: tb/sim_aux_retry_seq.sv
module sim_aux_retry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 24000;
    localparam int POLL_CYC   = 20;
    localparam int BACKOFF    = 8;
    localparam int LEN_W      = 5;
    localparam int DIV_W      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start0 = 1'b0, start1 = 1'b0;
    logic [LEN_W-1:0] send_len = 5'd4, recv_cap = 5'd8;
    logic eng_busy = 1'b0, eng_fin = 1'b0, eng_ok = 1'b0, eng_rx_err = 1'b0, eng_to_err = 1'b0;
    logic [LEN_W-1:0] eng_rx_len = '0;

    logic clr0, load0, go0, done0, clr1, load1, go1, done1;
    logic [DIV_W-1:0] div0, div1;
    logic [2:0] res0, res1;
    logic [LEN_W-1:0] len0, len1;

    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aux_retry_seq #(.CLK_KHZ(CLK_KHZ), .POLL_CYC(POLL_CYC), .BACKOFF_CYC(BACKOFF), .ALT_TABLE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .send_len(send_len), .recv_cap(recv_cap),
        .eng_busy(eng_busy), .eng_fin(eng_fin), .eng_ok(eng_ok), .eng_rx_err(eng_rx_err),
        .eng_to_err(eng_to_err), .eng_rx_len(eng_rx_len), .eng_clr(clr0), .eng_load(load0),
        .eng_go(go0), .eng_div(div0), .done(done0), .result(res0), .rx_len(len0));

    aux_retry_seq #(.CLK_KHZ(CLK_KHZ), .POLL_CYC(POLL_CYC), .BACKOFF_CYC(BACKOFF), .ALT_TABLE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .send_len(send_len), .recv_cap(recv_cap),
        .eng_busy(eng_busy), .eng_fin(eng_fin), .eng_ok(eng_ok), .eng_rx_err(eng_rx_err),
        .eng_to_err(eng_to_err), .eng_rx_len(eng_rx_len), .eng_clr(clr1), .eng_load(load1),
        .eng_go(go1), .eng_div(div1), .done(done1), .result(res1), .rx_len(len1));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    // launch one exchange on instance s
    task automatic kick(input int s);
        @(negedge clk);
        if (s == 0) start0 = 1'b1; else start1 = 1'b1;
        @(negedge clk);
        start0 = 1'b0; start1 = 1'b0;
    endtask

    // wait for eng_go on instance s; reports cycle, divider and whether clear preceded it
    task automatic wait_go(input int s, output int at, output int dv, output bit clr_prev);
        bit last_clr = 1'b0;
        at = -1; dv = 0; clr_prev = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if ((s == 0 ? go0 : go1)) begin
                at = cyc; dv = int'(s == 0 ? div0 : div1); clr_prev = last_clr;
                return;
            end
            last_clr = (s == 0) ? (clr0 && load0) : (clr1 && load1);
            @(negedge clk);
        end
    endtask

    // engine reply one cycle after the launch; returns finish cycle
    task automatic reply(input bit ok, input bit rx, input bit to, input int len, output int fc);
        @(negedge clk);
        eng_fin = 1'b1; eng_ok = ok; eng_rx_err = rx; eng_to_err = to; eng_rx_len = LEN_W'(len);
        fc = cyc;
        @(negedge clk);
        eng_fin = 1'b0; eng_ok = 1'b0; eng_rx_err = 1'b0; eng_to_err = 1'b0;
    endtask

    task automatic wait_done(input int s, output int at);
        at = -1;
        for (int i = 0; i < 2000; i++) begin
            if ((s == 0 ? done0 : done1)) begin at = cyc; return; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R12 done low", int'(done0), 0);
        check("R12 go low", int'(go0 | clr0 | load0), 0);
    endtask

    task automatic t_too_big(input int sl, input int rc);
        int gos = 0;
        send_len = LEN_W'(sl); recv_cap = LEN_W'(rc);
        kick(0);
        check("R1 done next cycle", int'(done0), 1);
        check("R1 result too big", int'(res0), 4);
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (go0) gos++; end
        check("R1 no launch", gos, 0);
        send_len = 5'd4; recv_cap = 5'd8;
    endtask

    task automatic t_busy();
        int t0, td, gos = 0;
        eng_busy = 1'b1;
        kick(0);
        t0 = cyc;
        td = -1;
        for (int i = 0; i < 500; i++) begin
            if (go0) gos++;
            if (done0) begin td = cyc; break; end
            @(negedge clk);
        end
        check("R2 busy result", int'(res0), 1);
        check("R2 no launch", gos, 0);
        check_ge("R2 poll spacing", td - t0, 2 * POLL_CYC);
        eng_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_success(input int cap, input int rep, input int exp_len);
        int at, dv, fc, dn; bit cp;
        recv_cap = LEN_W'(cap);
        kick(0);
        wait_go(0, at, dv, cp);
        check("R7 default divider", dv, (CLK_KHZ + 1000) / 2000);
        check("R3 clear before go", int'(cp), 1);
        reply(1'b1, 1'b0, 1'b0, rep, fc);
        wait_done(0, dn);
        check("R9 ok result", int'(res0), 0);
        check("R9 clipped length", int'(len0), exp_len);
        @(negedge clk);
        check("R11 done pulse", int'(done0), 0);
        check("R11 result held", int'(res0), 0);
        recv_cap = 5'd8;
    endtask

    task automatic t_bad_len(input int rep);
        int at, dv, fc, dn; bit cp;
        kick(0);
        wait_go(0, at, dv, cp);
        reply(1'b1, 1'b0, 1'b0, rep, fc);
        wait_done(0, dn);
        check("R10 forbidden length busy", int'(res0), 1);
    endtask

    task automatic t_timeouts();
        int at, dv, fc, dn, gos = 0; bit cp;
        kick(0);
        wait_go(0, at, dv, cp);
        for (int k = 0; k < 5; k++) begin
            gos++;
            reply(1'b0, 1'b0, 1'b1, 0, fc);
            if (k < 4) begin
                wait_go(0, at, dv, cp);
                check("R4 immediate relaunch gap", at - fc, 2);
                check("R3 clear precedes relaunch", int'(cp), 1);
            end
        end
        wait_done(0, dn);
        check("R6 attempts per divider", gos, 5);
        check("R8 timeout result", int'(res0), 3);
    endtask

    task automatic t_rx_errors();
        int at, dv, fc, dn; bit cp;
        kick(0);
        wait_go(0, at, dv, cp);
        for (int k = 0; k < 5; k++) begin
            reply(1'b0, 1'b1, 1'b0, 0, fc);
            if (k < 4) begin
                wait_go(0, at, dv, cp);
                check_ge("R5 back-off gap", at - fc, BACKOFF);
            end
        end
        wait_done(0, dn);
        check("R8 IO error result", int'(res0), 2);
    endtask

    task automatic t_alt_table();
        int at, dv, fc, dn, gos = 0; bit cp;
        kick(1);
        for (int k = 0; k < 10; k++) begin
            wait_go(1, at, dv, cp);
            if (at < 0) break;
            gos++;
            if (k == 0) check("R7 alt first divider", dv, 63);
            if (k == 5) check("R7 alt second divider", dv, 72);
            reply(1'b0, 1'b0, 1'b1, 0, fc);
        end
        wait_done(1, dn);
        check("R6 two dividers ten attempts", gos, 10);
        check("R8 alt timeout result", int'(res1), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_too_big(21, 8);
        t_too_big(4, 21);
        t_busy();
        t_success(8, 5, 5);
        t_success(4, 9, 4);
        t_success(20, 20, 20);
        t_bad_len(0);
        t_bad_len(25);
        t_timeouts();
        t_rx_errors();
        t_alt_table();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule